// File: doc/BRIEF.md
# Bit Clock Loss Powerdown Monitor

This block guards a voice codec's control port against the loss of its 2.048 MHz serial bit clock. A slow, free-running reference clock of about 1 MHz, unrelated to the bit clock, observes the bit clock. When the bit clock freezes at a high level for long enough, the block raises a powerdown flag. That flag has the same effect downstream as a software powerdown: the PCM output is released to high impedance and most internal clocks stop. The discrete drive outputs are handled elsewhere and stay unaffected. A bit clock frozen low is not detected, because the surrounding logic is undefined in that case anyway.

Activity is carried across the domains as a divided toggle from the bit-clock domain. Synchronized toggle edges, or a sampled low level, restart a stall counter in the reference domain. The loss flag is set when that counter reaches its limit while the synchronized bit-clock level is still high. The flag is driven into the bit-clock domain through an asynchronously set synchronizer, so powerdown takes effect without any bit-clock edge. Its release waits for returning bit-clock edges. After reset the block also holds powerdown for 25 bit clocks, and during that time it raises a strobe that forces the control registers to their powerdown contents.

Top module: `bclk_loss_pd_mon`

## Requirements
- R1: With default parameters, once the bit clock stays high, pd_o stays low for at least 10 reference periods and is high within 40 reference periods.
- R2: A bit clock held low for any length of time never raises pd_o.
- R3: The bit clock may pause high for 9 reference periods or less and then resume toggling; pd_o then stays low throughout.
- R4: After a stuck-high loss, the loss flag clears two reference periods after the first detected bit-clock activity. pd_o is still high one reference period after toggling resumes and is low within 30 reference periods.
- R5: After reset is released, force_o and pd_o stay high through the 24th rising bit-clock edge. force_o falls on the 25th edge, and pd_o falls with it when no clock loss is present. force_o high always implies pd_o high.
- R6: While rst_n_i is low, pd_o and force_o are both high.
- R7: Clock loss never raises force_o. Once force_o is low, it stays low until the next reset.
- R8: A steadily toggling bit clock leaves pd_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Free-running reference clock, about 1 MHz, independent of the bit clock |
| bclk_i | input | 1 | Serial bit clock being watched |
| rst_n_i | input | 1 | Active-low asynchronous power-on reset |
| pd_o | output | 1 | Powerdown flag, in the bit-clock domain and set asynchronously on clock loss |
| force_o | output | 1 | Strobe that forces the control registers to powerdown contents during the power-up hold |

## Verification
The hardest situation to reach from the ports is a clock that stops high right after a long low stall. In that case the stall counter must not take credit for the low time, so the full minimum window still applies. The bench reaches it by first freezing the clock low, then switching the frozen level to high. It samples the flag at the early and late window bounds.

The bench also freezes the clock high at random points in its divide phase, and issues short high pauses just below the window. Both exercise the gap between divided-toggle activity and level sampling, which lies inside the design and cannot be observed directly.

// File: rtl/bclk_mon_pkg.sv
`timescale 1ns/100ps
package bclk_mon_pkg;
    localparam int unsigned DEF_DIV_LOG2       = 3;
    localparam int unsigned DEF_SYNC_STAGES    = 2;
    localparam int unsigned DEF_STALL_LIMIT    = 20;
    localparam int unsigned DEF_RECOVER_CYCLES = 2;
    localparam int unsigned DEF_HOLD_CYCLES    = 25;

    // Bits needed to hold the values 0..maxval.
    function automatic int unsigned cnt_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction
endpackage

// File: rtl/bclk_mon_activity.sv
`timescale 1ns/100ps
// Bit-clock domain: a level that flips every 2**DIV_LOG2 rising edges.
module bclk_mon_activity
    import bclk_mon_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = DEF_DIV_LOG2
) (
    input  logic bclk_i,
    input  logic rst_n_i,
    output logic act_o
);
    localparam int unsigned DIV_W = (DIV_LOG2 > 0) ? DIV_LOG2 : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             tog;
    } act_t;

    act_t s_d, s_q;

    generate
        if (DIV_LOG2 == 0) begin : g_direct
            always_comb begin
                s_d     = s_q;
                s_d.tog = ~s_q.tog;
            end
        end else begin : g_divided
            always_comb begin
                s_d     = s_q;
                s_d.div = s_q.div + 1'b1;
                if (&s_q.div) begin
                    s_d.tog = ~s_q.tog;
                end
            end
        end
    endgenerate

    always_ff @(posedge bclk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_o = s_q.tog;
endmodule

// File: rtl/bclk_mon_watch.sv
`timescale 1ns/100ps
// Reference domain: synchronizes activity and level, times the stall,
// and owns the loss flag with its delayed release.
module bclk_mon_watch
    import bclk_mon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = DEF_SYNC_STAGES,
    parameter int unsigned STALL_LIMIT    = DEF_STALL_LIMIT,
    parameter int unsigned RECOVER_CYCLES = DEF_RECOVER_CYCLES
) (
    input  logic ref_clk_i,
    input  logic rst_n_i,
    input  logic act_i,
    input  logic bclk_i,
    output logic loss_o,
    output logic act_edge_o
);
    localparam int unsigned IDLE_W = cnt_width(STALL_LIMIT);
    localparam int unsigned REC_W  = cnt_width(RECOVER_CYCLES);
    localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(STALL_LIMIT);
    localparam logic [REC_W-1:0]  REC_LOAD = REC_W'(RECOVER_CYCLES);
    localparam logic [REC_W-1:0]  REC_LAST = REC_W'(1);

    typedef struct packed {
        logic [SYNC_STAGES:0]   act_sh;
        logic [SYNC_STAGES-1:0] lvl_sh;
        logic [IDLE_W-1:0]      idle;
        logic [REC_W-1:0]       rec;
        logic                   loss;
    } watch_t;

    watch_t w_d, w_q;
    logic   act_edge;
    logic   lvl_hi;

    always_comb begin
        w_d      = w_q;
        act_edge = w_q.act_sh[SYNC_STAGES] ^ w_q.act_sh[SYNC_STAGES-1];
        lvl_hi   = w_q.lvl_sh[SYNC_STAGES-1];

        w_d.act_sh = {w_q.act_sh[SYNC_STAGES-1:0], act_i};
        w_d.lvl_sh = {w_q.lvl_sh[SYNC_STAGES-2:0], bclk_i};

        // Stall time only accumulates while the clock reads high and quiet.
        if (act_edge || !lvl_hi) begin
            w_d.idle = '0;
        end else if (w_q.idle != IDLE_MAX) begin
            w_d.idle = w_q.idle + 1'b1;
        end

        if (!w_q.loss) begin
            w_d.rec = '0;
            if (lvl_hi && !act_edge && (w_q.idle == IDLE_MAX)) begin
                w_d.loss = 1'b1;
            end
        end else if (w_q.rec != '0) begin
            w_d.rec = w_q.rec - 1'b1;
            if (w_q.rec == REC_LAST) begin
                w_d.loss = 1'b0;
            end
        end else if (act_edge) begin
            if (RECOVER_CYCLES == 0) begin
                w_d.loss = 1'b0;
            end else begin
                w_d.rec = REC_LOAD;
            end
        end
    end

    always_ff @(posedge ref_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign loss_o     = w_q.loss;
    assign act_edge_o = act_edge;
endmodule

// File: rtl/bclk_mon_hold.sv
`timescale 1ns/100ps
// Bit-clock domain: power-up hold counter and the loss synchronizer,
// which sets at once and releases only on bit-clock edges.
module bclk_mon_hold
    import bclk_mon_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = DEF_HOLD_CYCLES,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic bclk_i,
    input  logic rst_n_i,
    input  logic loss_i,
    output logic pd_o,
    output logic force_o
);
    localparam int unsigned HOLD_W = cnt_width(HOLD_CYCLES);
    localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(HOLD_CYCLES);

    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
        logic              hold;
    } hold_t;

    hold_t                  h_d, h_q;
    logic [SYNC_STAGES-1:0] lsync_d, lsync_q;

    always_comb begin
        h_d = h_q;
        if (h_q.cnt != HOLD_END) begin
            h_d.cnt = h_q.cnt + 1'b1;
        end
        h_d.hold = (h_d.cnt != HOLD_END);
        lsync_d  = {lsync_q[SYNC_STAGES-2:0], 1'b0};
    end

    always_ff @(posedge bclk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            h_q.cnt  <= '0;
            h_q.hold <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    always_ff @(posedge bclk_i or negedge rst_n_i or posedge loss_i) begin
        if (!rst_n_i) begin
            lsync_q <= '0;
        end else if (loss_i) begin
            lsync_q <= '1;
        end else begin
            lsync_q <= lsync_d;
        end
    end

    assign force_o = h_q.hold;
    assign pd_o    = h_q.hold | lsync_q[SYNC_STAGES-1];
endmodule

// File: rtl/bclk_loss_pd_mon.sv
`timescale 1ns/100ps
module bclk_loss_pd_mon
    import bclk_mon_pkg::*;
#(
    parameter int unsigned DIV_LOG2       = DEF_DIV_LOG2,
    parameter int unsigned SYNC_STAGES    = DEF_SYNC_STAGES,
    parameter int unsigned STALL_LIMIT    = DEF_STALL_LIMIT,
    parameter int unsigned RECOVER_CYCLES = DEF_RECOVER_CYCLES,
    parameter int unsigned HOLD_CYCLES    = DEF_HOLD_CYCLES
) (
    input  logic ref_clk_i,
    input  logic bclk_i,
    input  logic rst_n_i,
    output logic pd_o,
    output logic force_o
);
    logic act_tog;
    logic loss_ref;
    logic act_edge;

    bclk_mon_activity #(
        .DIV_LOG2 (DIV_LOG2)
    ) u_activity (
        .bclk_i  (bclk_i),
        .rst_n_i (rst_n_i),
        .act_o   (act_tog)
    );

    bclk_mon_watch #(
        .SYNC_STAGES    (SYNC_STAGES),
        .STALL_LIMIT    (STALL_LIMIT),
        .RECOVER_CYCLES (RECOVER_CYCLES)
    ) u_watch (
        .ref_clk_i  (ref_clk_i),
        .rst_n_i    (rst_n_i),
        .act_i      (act_tog),
        .bclk_i     (bclk_i),
        .loss_o     (loss_ref),
        .act_edge_o (act_edge)
    );

    bclk_mon_hold #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_hold (
        .bclk_i  (bclk_i),
        .rst_n_i (rst_n_i),
        .loss_i  (loss_ref),
        .pd_o    (pd_o),
        .force_o (force_o)
    );
endmodule

// File: rtl/bclk_loss_pd_mon_chk.sv
`timescale 1ns/100ps
module bclk_loss_pd_mon_chk
    import bclk_mon_pkg::*;
#(
    parameter int unsigned MIN_HIGH       = 10,
    parameter int unsigned RECOVER_CYCLES = DEF_RECOVER_CYCLES,
    parameter int unsigned HOLD_CYCLES    = DEF_HOLD_CYCLES
) (
    input logic ref_clk_i,
    input logic bclk_i,
    input logic rst_n_i,
    input logic loss_ref,
    input logic act_edge,
    input logic pd_o,
    input logic force_o
);
    localparam int unsigned HI_W  = cnt_width(MIN_HIGH);
    localparam int unsigned ARM_W = cnt_width(RECOVER_CYCLES + 1);
    localparam int unsigned BC_W  = cnt_width(HOLD_CYCLES + 1);

    logic [HI_W-1:0]  hi_cnt;
    logic [ARM_W-1:0] arm_cnt;
    logic [BC_W-1:0]  bcnt;

    // Raw high time of the bit clock as seen by the reference clock.
    always_ff @(posedge ref_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            hi_cnt <= '0;
        end else if (!bclk_i) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HI_W'(MIN_HIGH)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // Reference cycles since the first activity seen during a loss.
    always_ff @(posedge ref_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            arm_cnt <= '0;
        end else if (!loss_ref) begin
            arm_cnt <= '0;
        end else if (arm_cnt != '0) begin
            if (arm_cnt != '1) begin
                arm_cnt <= arm_cnt + 1'b1;
            end
        end else if (act_edge) begin
            arm_cnt <= ARM_W'(1);
        end
    end

    // Rising bit-clock edges since reset.
    always_ff @(posedge bclk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            bcnt <= '0;
        end else if (bcnt != BC_W'(HOLD_CYCLES + 1)) begin
            bcnt <= bcnt + 1'b1;
        end
    end

    p_min_high_r1: assert property (@(posedge ref_clk_i) disable iff (!rst_n_i)
        $rose(loss_ref) |-> (hi_cnt == HI_W'(MIN_HIGH)));

    p_pd_follows_loss_r1: assert property (@(posedge ref_clk_i) disable iff (!rst_n_i)
        loss_ref |-> pd_o);

    p_no_loss_when_low_r2: assert property (@(posedge ref_clk_i) disable iff (!rst_n_i)
        $rose(loss_ref) |-> bclk_i);

    p_release_delay_r4: assert property (@(posedge ref_clk_i) disable iff (!rst_n_i)
        $fell(loss_ref) |-> (arm_cnt == ARM_W'(RECOVER_CYCLES + 1)));

    p_hold_length_r5: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        $fell(force_o) |-> (bcnt == BC_W'(HOLD_CYCLES)));

    p_force_has_pd_r5: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        force_o |-> pd_o);

    p_force_stays_low_r7: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        !force_o |=> !force_o);
endmodule

bind bclk_loss_pd_mon bclk_loss_pd_mon_chk #(
    .RECOVER_CYCLES (RECOVER_CYCLES),
    .HOLD_CYCLES    (HOLD_CYCLES)
) u_chk (
    .ref_clk_i (ref_clk_i),
    .bclk_i    (bclk_i),
    .rst_n_i   (rst_n_i),
    .loss_ref  (loss_ref),
    .act_edge  (act_edge),
    .pd_o      (pd_o),
    .force_o   (force_o)
);

// File: tb/bclk_loss_pd_mon_bench.sv
`timescale 1ns/100ps
module bclk_loss_pd_mon_bench;
    localparam int REF_NS  = 10;
    localparam int HOLD    = 25;
    localparam int MIN_NS  = 10 * REF_NS;
    localparam int MAX_NS  = 40 * REF_NS;
    localparam int WD_NS   = 1_000_000;

    logic ref_clk = 1'b0;
    logic bclk    = 1'b0;
    logic rst_n   = 1'b0;
    logic run     = 1'b1;
    logic stop_lvl = 1'b0;
    logic pd, frc;
    int   checks = 0;
    int   errors = 0;

    always #5 ref_clk = ~ref_clk;
    always #2.4 bclk = run ? ~bclk : stop_lvl;

    bclk_loss_pd_mon u_bclk_loss_pd_mon (
        .ref_clk_i (ref_clk),
        .bclk_i    (bclk),
        .rst_n_i   (rst_n),
        .pd_o      (pd),
        .force_o   (frc)
    );

    // Expected flag after the clock has been held high for ns nanoseconds.
    function automatic logic exp_pd_stuck_high(input int ns);
        return (ns <= MIN_NS) ? 1'b0 : 1'b1;
    endfunction

    // Expected flag ns nanoseconds after toggling resumes from a loss.
    function automatic logic exp_pd_resumed(input int ns);
        return (ns <= REF_NS) ? 1'b1 : 1'b0;
    endfunction

    function automatic logic exp_force(input int edges);
        return (edges < HOLD) ? 1'b1 : 1'b0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Sample point kept clear of every clock edge of both clocks.
    task automatic wait_ref(input int n);
        repeat (n) @(posedge ref_clk);
        #2.5;
    endtask

    task automatic hold_sequence;
        repeat (HOLD - 1) @(posedge bclk);
        #1.2;
        check("R5 force before last hold edge", frc, exp_force(HOLD - 1));
        check("R5 pd during hold", pd, 1'b1);
        @(posedge bclk);
        #1.2;
        check("R5 force after hold edge", frc, exp_force(HOLD));
        check("R5 pd after hold", pd, 1'b0);
    endtask

    initial begin
        #(WD_NS);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7731));
        rst_n = 1'b0;
        wait_ref(5);
        check("R6 pd in reset", pd, 1'b1);
        check("R6 force in reset", frc, 1'b1);
        rst_n = 1'b1;
        hold_sequence();

        // R8: steady toggling
        for (int i = 0; i < 10; i++) begin
            wait_ref(1 + int'($urandom % 20));
            check("R8 running clock", pd, 1'b0);
        end

        // R1 / R4 / R7: stuck high at random divide phases
        for (int i = 0; i < 6; i++) begin
            wait_ref(20 + int'($urandom % 60));
            stop_lvl = 1'b1;
            run = 1'b0;
            wait_ref(10);
            check("R1 early bound", pd, exp_pd_stuck_high(MIN_NS));
            wait_ref(30);
            check("R1 late bound", pd, exp_pd_stuck_high(MAX_NS));
            check("R7 force during loss", frc, 1'b0);
            wait_ref(int'($urandom % 20));
            run = 1'b1;
            #10;
            check("R4 still down after resume", pd, exp_pd_resumed(REF_NS));
            wait_ref(30);
            check("R4 released", pd, exp_pd_resumed(30 * REF_NS));
            wait_ref(20);
        end

        // R3: short high pauses
        for (int i = 0; i < 4; i++) begin
            wait_ref(10 + int'($urandom % 30));
            stop_lvl = 1'b1;
            run = 1'b0;
            for (int k = 0; k < 9; k++) begin
                wait_ref(1);
                check("R3 during pause", pd, 1'b0);
            end
            run = 1'b1;
            for (int k = 0; k < 20; k++) begin
                wait_ref(1);
                check("R3 after pause", pd, 1'b0);
            end
        end

        // R2: stuck low, then R1 from a low stall switching to high
        stop_lvl = 1'b0;
        run = 1'b0;
        wait_ref(30);
        check("R2 stuck low mid", pd, 1'b0);
        wait_ref(30);
        check("R2 stuck low end", pd, 1'b0);
        stop_lvl = 1'b1;
        wait_ref(10);
        check("R1 early bound after low stall", pd, exp_pd_stuck_high(MIN_NS));
        wait_ref(30);
        check("R1 late bound after low stall", pd, exp_pd_stuck_high(MAX_NS));
        run = 1'b1;
        wait_ref(40);
        check("R4 released after low stall", pd, 1'b0);

        // R6 / R5: reset in mid run, hold repeats
        wait_ref(7);
        rst_n = 1'b0;
        #1;
        check("R6 pd on mid-run reset", pd, 1'b1);
        check("R6 force on mid-run reset", frc, 1'b1);
        wait_ref(3);
        rst_n = 1'b1;
        hold_sequence();
        wait_ref(10);
        check("R7 force stays low", frc, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule